// File: doc/BRIEF.md
# Register-Addressed Serial Slave with Bit-Run Resynchronisation

This block sits between a host's serial port and the register set of a converter. The host runs the serial clock, chip select and data line. Every access begins with an 8-bit command byte. The command byte names one of three registers and says whether the next transfer reads or writes it. After that transfer the block goes back to waiting for a new command byte. There is an 8-bit setup register, which drives the converter's mode pins. There is an 8-bit test register, and any nonzero value in it raises a test-mode flag. There is also a 16-bit result register. The converter core loads the result register through a parallel valid/ready port, and the host can only read it.

The three serial pins are brought into the system clock domain through a synchroniser. The block then works on the edges it detects there. The result port never applies back-pressure: `res_ready` is held high, each cycle with `res_valid` high overwrites the result register, and the newest word wins. A host that has lost count of the frame can force the interface back to its waiting state by sending a long run of ones. Chip select gives a second way to recover.

Top module: `sif_slave`

## Requirements
- R1: After reset the interface waits for a command byte, `setup_q` is 0 (bipolar mode), `test_mode` is 0 and `sdo` is 0.
- R2: A command byte is shifted in MSB first. Bit 7 must be 0, otherwise the whole byte is ignored. Bits 5:4 select the target: 00 selects nothing (no data phase follows), 01 the setup register, 10 the test register and 11 the result register. Bit 3 set to 1 means read, and 0 means write.
- R3: A setup write takes 8 bits MSB first and the new value appears on `setup_q`; a setup read returns the current value. Field positions: bit 2 unipolar (0 = bipolar), bit 1 input buffer enable, bit 0 filter sync.
- R4: A test write takes 8 bits and a test read returns them; `test_mode` is high exactly when the test register is nonzero.
- R5: A cycle with `res_valid` high loads `res_data` into the result register, and `res_ready` is always high. A result read returns 16 bits MSB first, taken from the register as it stood at the end of the command byte.
- R6: A write aimed at the result register still consumes 16 bits and discards them. The result register is left unchanged and the next byte is treated as a command.
- R7: 32 consecutive ones sampled on `sdi` return the interface to waiting for a command byte from any state. Neither `setup_q` nor `test_mode` changes on that bit.
- R8: Test mode is left either by a hardware reset or by the 32-ones resynchronisation followed by a write of zero to the test register.
- R9: Raising `cs_n` aborts any partial transfer, returns the interface to waiting for a command byte, clears the run counter and drives `sdo` low.
- R10: `sdi` is sampled on rising `sclk` edges. `sdo` changes only after falling `sclk` edges. The first read bit appears after the falling edge that ends the command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| sclk | input | 1 | Serial clock from host, idles low |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| res_valid | input | 1 | Conversion result valid |
| res_ready | output | 1 | Result accepted (always high) |
| res_data | input | 16 | Conversion result word |
| setup_q | output | 8 | Setup register contents |
| test_mode | output | 1 | Test register is nonzero |

## Verification
The hardest situation to reach from the ports is resynchronisation from a frame whose alignment the host has lost. Stray ones then finish a command byte that was only partly sent and open an unintended read phase, so the run of ones crosses a frame boundary. The bench gets there in two steps. It first shifts three zeros, leaving the command half-built, and then sends 32 ones. It checks that the setup register survives and that a normal write works right afterwards. A second sequence enters test mode, resynchronises and writes zero, which checks the software exit path.

// File: rtl/sif_pkg.sv
package sif_pkg;
  typedef enum logic [1:0] {ST_CMD, ST_WR, ST_RD} sif_st_t;
  typedef enum logic [1:0] {SEL_NONE = 2'd0, SEL_SETUP = 2'd1, SEL_TEST = 2'd2, SEL_DATA = 2'd3} sif_sel_t;
  // command byte field positions
  localparam int CMD_START_BIT = 7;
  localparam int CMD_SEL_HI    = 5;
  localparam int CMD_SEL_LO    = 4;
  localparam int CMD_RD_BIT    = 3;
endpackage

// File: rtl/sif_sync.sv
module sif_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= RST_VAL;
    else        chain[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= RST_VAL;
      else        chain[g] <= chain[g-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sif_ones_det.sv
module sif_ones_det #(
  parameter int RUN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  input  logic bit_in,
  output logic hit
);
  localparam int CW = $clog2(RUN + 1);
  logic [CW-1:0] cnt_q;

  assign hit = step && bit_in && (cnt_q == CW'(RUN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (clr)             cnt_q <= '0;
    else if (step) begin
      if (!bit_in || hit)     cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sif_regfile.sv
module sif_regfile #(
  parameter int REG_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_setup,
  input  logic              wr_test,
  input  logic [REG_W-1:0]  wdata,
  input  logic              ld_data,
  input  logic [DATA_W-1:0] ld_value,
  output logic [REG_W-1:0]  setup_q,
  output logic [REG_W-1:0]  test_q,
  output logic [DATA_W-1:0] data_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_q <= '0;
      test_q  <= '0;
      data_q  <= '0;
    end else begin
      if (wr_setup) setup_q <= wdata;
      if (wr_test)  test_q  <= wdata;
      if (ld_data)  data_q  <= ld_value;
    end
  end
endmodule

// File: rtl/sif_slave.sv
module sif_slave
  import sif_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RESYNC_ONES = 32,
  parameter int DATA_W = 16,
  parameter int REG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              sdi,
  output logic              sdo,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [DATA_W-1:0] res_data,
  output logic [REG_W-1:0]  setup_q,
  output logic              test_mode
);
  localparam int CW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] CMD_LAST = CW'(REG_W - 1);

  logic [2:0] pins_s;
  logic sclk_s, cs_s, sdi_s, sclk_p;
  logic cs_act, rise_evt, fall_evt, ones_hit;

  sif_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sclk, cs_n, sdi}), .q(pins_s)
  );
  assign {sclk_s, cs_s, sdi_s} = pins_s;
  assign cs_act   = !cs_s;
  assign rise_evt = cs_act && sclk_s && !sclk_p;
  assign fall_evt = cs_act && !sclk_s && sclk_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_p <= 1'b0;
    else        sclk_p <= sclk_s;
  end

  sif_ones_det #(.RUN(RESYNC_ONES)) u_ones (
    .clk(clk), .rst_n(rst_n), .clr(!cs_act), .step(rise_evt), .bit_in(sdi_s), .hit(ones_hit)
  );

  sif_st_t           state_q;
  sif_sel_t          sel_q, cmd_sel;
  logic [CW-1:0]     cnt_q, len_m1;
  logic [DATA_W-1:0] rx_q, tx_q, nxt_rx, rd_val;
  logic [REG_W-1:0]  test_q;
  logic [DATA_W-1:0] data_q;
  logic              sdo_q, xfer_last, wr_setup, wr_test;

  assign nxt_rx    = {rx_q[DATA_W-2:0], sdi_s};
  assign cmd_sel   = sif_sel_t'(nxt_rx[CMD_SEL_HI:CMD_SEL_LO]);
  assign len_m1    = (sel_q == SEL_DATA) ? CW'(DATA_W - 1) : CW'(REG_W - 1);
  assign xfer_last = (cnt_q == len_m1);

  always_comb begin
    unique case (cmd_sel)
      SEL_SETUP: rd_val = {setup_q, {(DATA_W-REG_W){1'b0}}};
      SEL_TEST:  rd_val = {test_q,  {(DATA_W-REG_W){1'b0}}};
      SEL_DATA:  rd_val = data_q;
      default:   rd_val = '0;
    endcase
  end

  assign wr_setup = rise_evt && !ones_hit && state_q == ST_WR && xfer_last && sel_q == SEL_SETUP;
  assign wr_test  = rise_evt && !ones_hit && state_q == ST_WR && xfer_last && sel_q == SEL_TEST;

  sif_regfile #(.REG_W(REG_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_setup(wr_setup), .wr_test(wr_test), .wdata(nxt_rx[REG_W-1:0]),
    .ld_data(res_valid), .ld_value(res_data),
    .setup_q(setup_q), .test_q(test_q), .data_q(data_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_CMD;
      sel_q   <= SEL_NONE;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      sdo_q   <= 1'b0;
    end else if (!cs_act) begin
      state_q <= ST_CMD;
      cnt_q   <= '0;
      sdo_q   <= 1'b0;
    end else begin
      if (rise_evt) begin
        rx_q <= nxt_rx;
        if (ones_hit) begin
          state_q <= ST_CMD;
          cnt_q   <= '0;
        end else begin
          unique case (state_q)
            ST_CMD: begin
              if (cnt_q == CMD_LAST) begin
                cnt_q <= '0;
                if (!nxt_rx[CMD_START_BIT] && cmd_sel != SEL_NONE) begin
                  state_q <= nxt_rx[CMD_RD_BIT] ? ST_RD : ST_WR;
                  sel_q   <= cmd_sel;
                  tx_q    <= rd_val;
                end
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
            default: begin
              if (xfer_last) begin
                state_q <= ST_CMD;
                cnt_q   <= '0;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
          endcase
        end
      end
      if (fall_evt) begin
        if (state_q == ST_RD) begin
          sdo_q <= tx_q[DATA_W-1];
          tx_q  <= {tx_q[DATA_W-2:0], 1'b0};
        end else begin
          sdo_q <= 1'b0;
        end
      end
    end
  end

  assign sdo       = sdo_q;
  assign res_ready = 1'b1;
  assign test_mode = |test_q;
endmodule

// File: rtl/sif_slave_chk.sv
module sif_slave_chk #(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_act,
  input logic             rise_evt,
  input logic             fall_evt,
  input logic             ones_hit,
  input logic             sdo,
  input logic [REG_W-1:0] setup_q,
  input logic             test_mode
);
  // R9: deselect silences the output
  a_r9_sdo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !sdo);
  // R9: no register write while deselected
  a_r9_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> $stable(setup_q) && $stable(test_mode));
  // R10: sdo moves only after a falling serial edge or deselect
  a_r10_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> ($past(fall_evt) || $past(!cs_act)));
  // R3: setup changes only on a sampled rising edge
  a_r3_write_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(setup_q) |-> $past(rise_evt));
  // R7: the resync bit never writes a register
  a_r7_ones_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    ones_hit |=> $stable(setup_q) && $stable(test_mode));
  // R4: test flag changes only on a sampled rising edge
  a_r4_test_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(test_mode) |-> $past(rise_evt));
endmodule

bind sif_slave sif_slave_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .rise_evt(rise_evt), .fall_evt(fall_evt),
  .ones_hit(ones_hit), .sdo(sdo), .setup_q(setup_q), .test_mode(test_mode)
);

// File: tb/sim_sif_slave.sv
module sim_sif_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0, res_valid = 1'b0;
  logic [15:0] res_data = '0;
  logic sdo, res_ready, test_mode;
  logic [7:0] setup_q;
  int vectors = 0, miscompares = 0;

  always #4 clk = ~clk;

  sif_slave u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi), .sdo(sdo),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .setup_q(setup_q), .test_mode(test_mode)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // shift n bits MSB first; returns bits seen on sdo before each rising edge
  task automatic xfer(input logic [15:0] tx, input int n, output logic [15:0] rx);
    rx = '0;
    for (int i = n - 1; i >= 0; i--) begin
      sdi = tx[i];
      wait_clk(4);
      rx = {rx[14:0], sdo};
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
    end
  endtask

  task automatic select(input logic on);
    cs_n = !on;
    wait_clk(6);
  endtask

  task automatic wr8(input logic [7:0] cmd, input logic [7:0] v);
    logic [15:0] d;
    xfer({8'h0, cmd}, 8, d);
    xfer({8'h0, v}, 8, d);
  endtask

  task automatic rd(input logic [7:0] cmd, input int n, output logic [15:0] v);
    logic [15:0] d;
    xfer({8'h0, cmd}, 8, d);
    xfer(16'h0, n, v);
  endtask

  task automatic load_result(input logic [15:0] v);
    res_data = v;
    res_valid = 1'b1;
    wait_clk(1);
    res_valid = 1'b0;
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    logic [15:0] v;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(3);
    // R1 reset state
    chk("R1 setup", {8'h0, setup_q}, 16'h0);
    chk("R1 test_mode", {15'h0, test_mode}, 16'h0);
    chk("R1 sdo", {15'h0, sdo}, 16'h0);
    chk("R5 res_ready", {15'h0, res_ready}, 16'h1);
    select(1'b1);
    // R3 exhaustive setup sweep: port and serial read back
    for (int k = 0; k < 256; k++) begin
      wr8(8'h10, 8'(k));
      wait_clk(4);
      chk("R3 setup_q", {8'h0, setup_q}, 16'(k));
      rd(8'h18, 8, v);
      chk("R3 setup read", v, 16'(k));
    end
    // R3 field positions: unipolar bit 2, buffer bit 1, fsync bit 0
    wr8(8'h10, 8'h04);
    wait_clk(4);
    chk("R3 unipolar bit2", {15'h0, setup_q[2]}, 16'h1);
    // R4 test register sweep over walking ones and zero
    for (int k = 0; k < 9; k++) begin
      logic [7:0] t;
      t = (k == 8) ? 8'h00 : 8'(1 << k);
      wr8(8'h20, t);
      wait_clk(4);
      chk("R4 test_mode", {15'h0, test_mode}, {15'h0, t != 0});
      rd(8'h28, 8, v);
      chk("R4 test read", v, {8'h0, t});
    end
    // R5 result reads, several patterns
    for (int k = 0; k < 8; k++) begin
      logic [15:0] p;
      p = 16'(16'hA5C3 * (k + 1) ^ (k << 11));
      load_result(p);
      rd(8'h38, 16, v);
      chk("R5 result read", v, p);
    end
    // R5 newest word wins
    load_result(16'h1111);
    load_result(16'hBEEF);
    rd(8'h38, 16, v);
    chk("R5 latest result", v, 16'hBEEF);
    // R6 write to result register discarded, next byte is a command
    wr8(8'h10, 8'h3C);
    xfer(16'h0030, 8, v);
    xfer(16'h5A5A, 16, v);
    wr8(8'h10, 8'h81);
    wait_clk(4);
    chk("R6 next command", {8'h0, setup_q}, 16'h0081);
    rd(8'h38, 16, v);
    chk("R6 result unchanged", v, 16'hBEEF);
    // R2 command with bit7 set is ignored
    wr8(8'h10, 8'h22);
    xfer(16'h0090, 8, v);
    xfer(16'h0010, 8, v);
    xfer(16'h0077, 8, v);
    wait_clk(4);
    chk("R2 start bit ignored", {8'h0, setup_q}, 16'h0077);
    // R2 select 00 has no data phase
    xfer(16'h0000, 8, v);
    wr8(8'h10, 8'h66);
    wait_clk(4);
    chk("R2 select none", {8'h0, setup_q}, 16'h0066);
    // R7 resync from a misaligned frame
    xfer(16'h0000, 3, v);
    xfer(16'hFFFF, 16, v);
    xfer(16'hFFFF, 16, v);
    wait_clk(4);
    chk("R7 regs kept", {8'h0, setup_q}, 16'h0066);
    wr8(8'h10, 8'h42);
    wait_clk(4);
    chk("R7 aligned after run", {8'h0, setup_q}, 16'h0042);
    // R8 leave test mode by run of ones then zero write
    wr8(8'h20, 8'h80);
    wait_clk(4);
    chk("R8 test entered", {15'h0, test_mode}, 16'h1);
    xfer(16'hFFFF, 16, v);
    xfer(16'hFFFF, 16, v);
    wait_clk(4);
    chk("R8 still in test", {15'h0, test_mode}, 16'h1);
    wr8(8'h20, 8'h00);
    wait_clk(4);
    chk("R8 test left", {15'h0, test_mode}, 16'h0);
    // R9 abort partial frame with cs_n
    xfer(16'h0001, 4, v);
    select(1'b0);
    chk("R9 sdo idle", {15'h0, sdo}, 16'h0);
    select(1'b1);
    wr8(8'h10, 8'h19);
    wait_clk(4);
    chk("R9 fresh after abort", {8'h0, setup_q}, 16'h0019);
    // R9 abort mid-read drives sdo low
    load_result(16'hFFFF);
    xfer(16'h0038, 8, v);
    xfer(16'h0, 3, v);
    chk("R10 first read bits", v, 16'h0007);
    select(1'b0);
    chk("R9 sdo low after abort", {15'h0, sdo}, 16'h0);
    // R10 sdo stays put across a rising edge during read
    select(1'b1);
    xfer(16'h0038, 8, v);
    sdi = 1'b0;
    wait_clk(4);
    chk("R10 bit before rise", {15'h0, sdo}, 16'h1);
    sclk = 1'b1;
    wait_clk(4);
    chk("R10 held through rise", {15'h0, sdo}, 16'h1);
    sclk = 1'b0;
    wait_clk(4);
    xfer(16'h0, 15, v);
    // R8 hardware reset leaves test mode
    wr8(8'h20, 8'h05);
    wait_clk(4);
    chk("R8 test set", {15'h0, test_mode}, 16'h1);
    rst_n = 1'b0;
    wait_clk(2);
    rst_n = 1'b1;
    wait_clk(6);
    chk("R8 reset clears test", {15'h0, test_mode}, 16'h0);
    chk("R1 setup after reset", {8'h0, setup_q}, 16'h0);
    summary();
  end
endmodule